// File: doc/BRIEF.md
# Page-mode flash read controller

This block sits on the host side of an asynchronous parallel flash device and turns single read requests into bus accesses. A request carries an address. Once it is accepted, the controller drives the flash address, chip enable, output enable, write enable and bus-width control, waits a fixed number of clock cycles, samples the data bus and returns the result with a one-cycle response pulse. Only one request is in flight at a time.

The flash returns data faster when a read stays inside the page opened by the previous access. The controller keeps a tag and a valid flag for the open page. A request that hits the open page waits the short page time, and any other request waits the full random-access time. Both wait counts come from access times in picoseconds, divided by the clock period and rounded up.

A configuration input selects 16-bit word or 8-bit byte bus mode per request. The open page is dropped when the mode changes. It is also dropped when the bus has sat idle long enough that chip enable is released to save power.

Top module: `pflash_rd_ctrl`

## Requirements
- R1: While reset is active and right after it, fl_ce_n_o, fl_oe_n_o, fl_we_n_o and fl_byte_n_o are 1, req_ready_o is 1 and rsp_valid_o is 0.
- R2: A read that misses the open page raises rsp_valid_o exactly RAND_CYC = ceil(T_RAND_PS / CLK_PERIOD_PS) clock edges after the accepting edge. The defaults give 9.
- R3: A read that hits the open page raises rsp_valid_o exactly PAGE_CYC = ceil(T_PAGE_PS / CLK_PERIOD_PS) edges after the accepting edge. The defaults give 4.
- R4: A page is identified by req_addr_i[19:3] in word mode and by req_addr_i[20:4] in byte mode. Any location in the open page, in any order, is a hit.
- R5: In word mode (byte_mode_i = 0) fl_addr_o is req_addr_i[19:0], fl_lsb_o is 0, req_addr_i[20] is ignored and rsp_data_o is fl_dq_i[15:0]. In byte mode fl_addr_o is req_addr_i[20:1], fl_lsb_o is req_addr_i[0] and rsp_data_o is {8'h00, fl_dq_i[7:0]}.
- R6: During an access fl_byte_n_o equals the inverse of the byte_mode_i value that was accepted with it. A request whose mode differs from the open page's mode is a miss.
- R7: fl_we_n_o is always 1. fl_oe_n_o is 0 only while an access is in flight, and only while fl_ce_n_o is 0.
- R8: req_ready_o is 0 from the cycle after the accepting edge until rsp_valid_o rises. rsp_valid_o is high for exactly one cycle per request.
- R9: fl_addr_o, fl_lsb_o and fl_byte_n_o stay unchanged for the whole of an access.
- R10: After IDLE_CYC consecutive idle cycles with no request pending, fl_ce_n_o returns to 1 and the next read is a miss. A shorter gap keeps the page open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | 21 | Read address: word address in bits 19..0, or byte address in bits 20..0 |
| byte_mode_i | input | 1 | 1 selects the 8-bit bus mode, 0 the 16-bit mode |
| rsp_valid_o | output | 1 | One-cycle pulse: rsp_data_o holds read data |
| rsp_data_o | output | 16 | Read data, zero-extended in byte mode |
| fl_addr_o | output | 20 | Flash address bus |
| fl_lsb_o | output | 1 | Extra low address bit used in byte mode |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_oe_n_o | output | 1 | Flash output enable, active low |
| fl_we_n_o | output | 1 | Flash write enable, active low (held high) |
| fl_byte_n_o | output | 1 | Flash bus width select, low for byte mode |
| fl_dq_i | input | 16 | Flash data bus |

## Verification
The main function is driven with word-mode reads that wander within one page, in ascending, descending and scattered order. These separate a real tag compare from a plain "same address" or "next address" check. Reads that cross into the neighbouring page, or go back to an earlier one, show that only the open page counts as a hit. Byte-mode reads at the two ends of a 16-byte page, followed by mode flips at an address that was just read, show that the page boundary moves with the mode and that a mode change forces the slow path. A word read that differs only in address bit 20, and idle gaps just below and well above the timeout, pin down which address bits form the tag and when power-down discards the page.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_BUSY} rd_state_e;

  function automatic int unsigned cyc_ceil(int unsigned t_ps, int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction
endpackage

// File: rtl/pflash_page_track.sv
module pflash_page_track #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned PG_BITS = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ADDR_W:0] lookup_addr_i,
  input  logic            lookup_byte_i,
  input  logic            update_i,
  input  logic            flush_i,
  output logic            hit_o
);
  localparam int unsigned TAG_W = ADDR_W - PG_BITS;

  logic [TAG_W-1:0] tag_q, lk_tag;
  logic             mode_q, valid_q;

  // byte mode shifts the page window up by one bit
  assign lk_tag = lookup_byte_i ? lookup_addr_i[ADDR_W:PG_BITS+1]
                                : lookup_addr_i[ADDR_W-1:PG_BITS];
  assign hit_o  = valid_q && (mode_q == lookup_byte_i) && (tag_q == lk_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      mode_q  <= 1'b0;
    end else if (update_i) begin
      valid_q <= 1'b1;
      tag_q   <= lk_tag;
      mode_q  <= lookup_byte_i;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end
  end

  assert_flush_drops_page_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !update_i) |=> !valid_q);
  assert_update_opens_page_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> valid_q);
endmodule

// File: rtl/pflash_wait_cnt.sv
module pflash_wait_cnt #(
  parameter int unsigned RAND_CYC = 9,
  parameter int unsigned PAGE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic page_i,
  output logic done_o
);
  localparam int unsigned CW      = $clog2(RAND_CYC + 1);
  localparam logic [CW-1:0] RAND_LD = CW'(RAND_CYC - 1);
  localparam logic [CW-1:0] PAGE_LD = CW'(PAGE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign done_o = active_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= page_i ? PAGE_LD : RAND_LD;
    end else if (done_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q <= RAND_LD));
  assert_start_when_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  assert_page_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && page_i) |=> (cnt_q == PAGE_LD));
endmodule

// File: rtl/pflash_idle_timer.sv
module pflash_idle_timer #(
  parameter int unsigned IDLE_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ce_on_i,
  output logic expire_o
);
  localparam int unsigned IW   = $clog2(IDLE_CYC + 1);
  localparam logic [IW-1:0] LAST = IW'(IDLE_CYC - 1);

  logic [IW-1:0] cnt_q;

  assign expire_o = ce_on_i && !hold_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (hold_i || !ce_on_i || expire_o) cnt_q <= '0;
    else                                    cnt_q <= cnt_q + 1'b1;
  end

  assert_idle_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pflash_rd_ctrl.sv
module pflash_rd_ctrl
  import pflash_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned T_RAND_PS     = 65000,
  parameter int unsigned T_PAGE_PS     = 25000,
  parameter int unsigned IDLE_CYC      = 32,
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned PG_BITS       = 3,
  parameter int unsigned DQ_W          = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [ADDR_W:0] req_addr_i,
  input  logic            byte_mode_i,
  output logic            rsp_valid_o,
  output logic [DQ_W-1:0] rsp_data_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic            fl_lsb_o,
  output logic            fl_ce_n_o,
  output logic            fl_oe_n_o,
  output logic            fl_we_n_o,
  output logic            fl_byte_n_o,
  input  logic [DQ_W-1:0] fl_dq_i
);
  localparam int unsigned RAND_CYC = cyc_ceil(T_RAND_PS, CLK_PERIOD_PS);
  localparam int unsigned PAGE_CYC = cyc_ceil(T_PAGE_PS, CLK_PERIOD_PS);
  localparam int unsigned LANE_W   = DQ_W / 2;

  rd_state_e state_q;
  logic      accept, hit, done, expire;
  logic [DQ_W-1:0] lane_data;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign fl_oe_n_o   = (state_q != ST_BUSY);
  assign fl_we_n_o   = 1'b1;

  // byte mode: upper lane is not data, zero it
  for (genvar g = 0; g < DQ_W; g++) begin : g_lane
    if (g < LANE_W) begin : g_lo
      assign lane_data[g] = fl_dq_i[g];
    end else begin : g_hi
      assign lane_data[g] = fl_byte_n_o & fl_dq_i[g];
    end
  end

  pflash_page_track #(.ADDR_W(ADDR_W), .PG_BITS(PG_BITS)) u_page (
    .clk_i, .rst_ni,
    .lookup_addr_i(req_addr_i),
    .lookup_byte_i(byte_mode_i),
    .update_i     (accept),
    .flush_i      (expire),
    .hit_o        (hit)
  );

  pflash_wait_cnt #(.RAND_CYC(RAND_CYC), .PAGE_CYC(PAGE_CYC)) u_wait (
    .clk_i, .rst_ni,
    .start_i(accept),
    .page_i (hit),
    .done_o (done)
  );

  pflash_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk_i, .rst_ni,
    .hold_i  (req_valid_i || (state_q == ST_BUSY)),
    .ce_on_i (!fl_ce_n_o),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fl_addr_o   <= '0;
      fl_lsb_o    <= 1'b0;
      fl_byte_n_o <= 1'b1;
      fl_ce_n_o   <= 1'b1;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept) begin
        state_q     <= ST_BUSY;
        fl_ce_n_o   <= 1'b0;
        fl_byte_n_o <= !byte_mode_i;
        fl_addr_o   <= byte_mode_i ? req_addr_i[ADDR_W:1] : req_addr_i[ADDR_W-1:0];
        fl_lsb_o    <= byte_mode_i & req_addr_i[0];
      end else if (state_q == ST_BUSY && done) begin
        state_q     <= ST_IDLE;
        rsp_valid_o <= 1'b1;
        rsp_data_o  <= lane_data;
      end else if (expire) begin
        fl_ce_n_o   <= 1'b1;
      end
    end
  end

  assert_oe_with_ce_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_n_o |-> !fl_ce_n_o);
  assert_bus_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && $past(state_q == ST_BUSY)) |->
      ($stable(fl_addr_o) && $stable(fl_lsb_o) && $stable(fl_byte_n_o)));
  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_ready_low_before_rsp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(!req_ready_o));
  assert_byte_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (fl_byte_n_o == !$past(byte_mode_i)));
endmodule

// File: tb/pflash_rd_ctrl_tb.sv
module pflash_rd_ctrl_tb_top;
  localparam int CLK_PS  = 8000;
  localparam int RAND_N  = (65000 + CLK_PS - 1) / CLK_PS;
  localparam int PAGE_N  = (25000 + CLK_PS - 1) / CLK_PS;
  localparam int IDLE_N  = 32;

  typedef struct packed {
    logic [20:0] a;
    logic        m;
    logic        hit;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{21'h00010, 1'b0, 1'b0},   // first word read: miss
    '{21'h00017, 1'b0, 1'b1},   // same page, top word
    '{21'h00011, 1'b0, 1'b1},   // same page, backwards
    '{21'h00018, 1'b0, 1'b0},   // next page
    '{21'h00010, 1'b0, 1'b0},   // back to previous page
    '{21'h00020, 1'b1, 1'b0},   // mode change to byte
    '{21'h0002F, 1'b1, 1'b1},   // byte page end
    '{21'h00021, 1'b1, 1'b1},   // byte page, odd byte
    '{21'h00030, 1'b1, 1'b0},   // next byte page
    '{21'h00030, 1'b0, 1'b0},   // same address, word mode
    '{21'h00037, 1'b0, 1'b1},
    '{21'h100031, 1'b0, 1'b1}   // bit 20 ignored in word mode
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, byte_mode = 1'b0;
  logic [20:0] req_addr = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [19:0] fl_addr;
  logic        fl_lsb, fl_ce_n, fl_oe_n, fl_we_n, fl_byte_n;
  logic [15:0] fl_dq, model_w;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4ns clk = ~clk;

  function automatic logic [15:0] fw(input logic [19:0] a);
    return a[15:0] ^ {4{a[19:16]}} ^ 16'h3C5A;
  endfunction

  // behavioural flash array
  assign model_w = fw(fl_addr);
  assign fl_dq = (!fl_ce_n && !fl_oe_n)
               ? (fl_byte_n ? model_w : {8'hEE, (fl_lsb ? model_w[15:8] : model_w[7:0])})
               : 16'hDEAD;

  function automatic logic [15:0] exp_data(input logic [20:0] a, input logic m);
    logic [15:0] w;
    if (m) begin
      w = fw(a[20:1]);
      return {8'h00, (a[0] ? w[15:8] : w[7:0])};
    end
    return fw(a[19:0]);
  endfunction

  pflash_rd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .byte_mode_i(byte_mode),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .fl_addr_o(fl_addr), .fl_lsb_o(fl_lsb), .fl_ce_n_o(fl_ce_n),
    .fl_oe_n_o(fl_oe_n), .fl_we_n_o(fl_we_n), .fl_byte_n_o(fl_byte_n),
    .fl_dq_i(fl_dq)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_read(input logic [20:0] a, input logic m, input int exp_lat, input string rq);
    int lat;
    @(negedge clk);
    byte_mode = m; req_addr = a; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    chk(req_ready == 1'b0, "R8 ready low", req_ready, 0);
    chk(fl_oe_n == 1'b0 && fl_ce_n == 1'b0, "R7 oe/ce low", {fl_oe_n, fl_ce_n}, 0);
    chk(fl_we_n == 1'b1, "R7 we high", fl_we_n, 1);
    chk(fl_byte_n == !m, "R6 byte pin", fl_byte_n, !m);
    if (m) chk(fl_addr == a[20:1] && fl_lsb == a[0], "R5 byte bus addr",
               {fl_addr, fl_lsb}, a);
    else   chk(fl_addr == a[19:0] && fl_lsb == 1'b0, "R5 word bus addr",
               {fl_addr, fl_lsb}, {a[19:0], 1'b0});
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, {rq, " latency"}, lat, exp_lat);
    chk(rsp_data == exp_data(a, m), "R5 data", rsp_data, exp_data(a, m));
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R8 pulse/ready", {rsp_valid, req_ready}, 1);
    chk(fl_oe_n == 1'b1, "R7 oe high when idle", fl_oe_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({fl_ce_n, fl_oe_n, fl_we_n, fl_byte_n} == 4'hF, "R1 bus in reset",
        {fl_ce_n, fl_oe_n, fl_we_n, fl_byte_n}, 4'hF);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake in reset",
        {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk({fl_ce_n, fl_oe_n, fl_we_n, fl_byte_n} == 4'hF, "R1 bus after reset",
        {fl_ce_n, fl_oe_n, fl_we_n, fl_byte_n}, 4'hF);

    // R2/R3/R4/R6 vector walk
    foreach (VECS[i]) begin
      do_read(VECS[i].a, VECS[i].m, VECS[i].hit ? PAGE_N : RAND_N,
              VECS[i].hit ? "R3 R4 hit" : "R2 R6 miss");
    end

    // R10: gap shorter than the timeout keeps the page
    do_read(21'h00040, 1'b0, RAND_N, "R2 miss");
    repeat (IDLE_N - 4) @(negedge clk);
    chk(fl_ce_n == 1'b0, "R10 ce held", fl_ce_n, 0);
    do_read(21'h00045, 1'b0, PAGE_N, "R10 short gap hit");

    // R10: timeout releases CE and drops the page
    repeat (IDLE_N + 4) @(negedge clk);
    chk(fl_ce_n == 1'b1 && fl_oe_n == 1'b1, "R10 ce released", {fl_ce_n, fl_oe_n}, 3);
    do_read(21'h00046, 1'b0, RAND_N, "R10 miss after timeout");
    do_read(21'h00041, 1'b0, PAGE_N, "R3 hit after reopen");

    // R6: flip mode at an address just read
    do_read(21'h00041, 1'b1, RAND_N, "R6 mode flip miss");
    do_read(21'h00040, 1'b1, PAGE_N, "R4 byte page hit");
    do_read(21'h0004F, 1'b1, PAGE_N, "R4 byte page end hit");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule